// File: doc/BRIEF.md
# Hybrid Counter and Delay-Tap Pulse-Width Modulator

This block drives the gate of a switching power converter with one pulse per switching period. The duty command is split in two. The upper part is compared against a coarse counter that runs on the system clock. The lower part selects one of a set of equally spaced phase taps that an external delay line supplies. When the coarse count reaches its match value, the chosen tap ends the pulse. The pulse can therefore end between two clock edges. This gives a duty resolution finer than the clock alone allows, while the clock stays far below 2^n times the switching rate.

A 2-bit rate select shortens the switching period by powers of two, so one clock can serve several switching rates. The duty word and the rate select are captured only when a period starts. A change in the middle of a period therefore cannot cut a pulse short or add a second one. The delay line itself is outside the block. Each tap input is a phase marker: it rises a fixed fraction of a clock period after every rising clock edge and stays high until the next rising edge.

Top module: `hdpwm`

## Requirements
- R1: With rate select s = 0, the high time in each period is (U*T + F) tap steps. Here U is duty_i[DUTY_W-1:FINE_W], F is duty_i[FINE_W-1:0], T = 2^FINE_W is the number of taps, and one tap step is 1/T of a clock period. Tap k rises k steps after each rising clock edge and stays high until the next edge; tap 0 is high from the edge.
- R2: Whenever a period's high time is non-zero, the output goes high at the clock edge where that period starts, and it is high at the start of the period's first tap step.
- R3: The output falls in the clock cycle where the coarse count equals the effective upper code, at the rising edge of tap F. It then stays low for the rest of the period, so each period has at most one pulse.
- R4: Rate select s (fsel_i, 2 bits) sets the period to 2^(CNT_W-s) clocks. It compares the counter against U >> s, so the high time per period is ((U>>s)*T + F) tap steps.
- R5: duty_i and fsel_i are captured only at the clock edge that starts a period. A change during a period has no effect until the next period.
- R6: A duty code of zero keeps the output low for the whole period.
- R7: The all-ones duty code with s = 0 holds the output high for 2^CNT_W*T - 1 tap steps. The output is low only during the last tap step of the period.
- R8: rst_n is a synchronous, active-low reset. While it is held, the output stays low. The first rising edge after release starts a period and captures the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the coarse counter advances on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| duty_i | input | DUTY_W | Duty command; upper CNT_W bits are coarse, lower FINE_W bits are fine |
| fsel_i | input | FSEL_W | Switching-rate select; the period is 2^(CNT_W-fsel_i) clocks |
| taps_i | input | 2^FINE_W | Phase markers from the external delay line; bit k rises k/2^FINE_W of a clock period after each edge |
| pwm_o | output | 1 | Gate pulse to the power stage |

## Verification
The case hardest to reach from the ports is a pulse edge that lies between two clock edges. It can be seen only if the stimulus models the delay line. The bench therefore re-creates each tap as a staircase of delayed rising markers within every clock cycle. It samples the output once in the middle of every tap step, so the high time is counted in tap steps. The bench changes the inputs only at multiples of the longest period. Every rate then stays aligned to the measurement window, which lets a full sweep over all duty codes and all rate selects be checked arithmetically. A duty change injected in the middle of a period shows that the capture happens only at the period start.

// File: rtl/hdpwm_pkg.sv
// Package: shared configuration helpers for the hybrid pulse-width modulator.
// Assumes widths are passed as plain integers from the instantiating module.
package hdpwm_pkg;

    // True when the split of the duty word and the rate select are consistent.
    function automatic bit cfg_ok(input int duty_w, input int cnt_w, input int fsel_w);
        return (cnt_w >= 1) && (duty_w > cnt_w) && (((1 << fsel_w) - 1) <= cnt_w);
    endfunction

    // Number of clocks in one switching period for a given rate select.
    function automatic int period_clocks(input int cnt_w, input int sel);
        return 1 << (cnt_w - sel);
    endfunction

endpackage

// File: rtl/hdpwm_coarse.sv
// Coarse stage: period counter, capture of the duty and rate select at each
// period start, and the coarse match against the shifted upper duty bits.
// Assumes the rate select never shortens the period below one clock.
module hdpwm_coarse #(
    parameter int DUTY_W = 8,
    parameter int CNT_W  = 3,
    parameter int FSEL_W = 2,
    localparam int FINE_W = DUTY_W - CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [FSEL_W-1:0] fsel_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  last_o,
    output logic [CNT_W-1:0]  up_o,
    output logic [FINE_W-1:0] fine_o,
    output logic [FSEL_W-1:0] sel_o,
    output logic              start_o,
    output logic              match_o,
    output logic              wrap_o
);

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  up_q;
    logic [FINE_W-1:0] fine_q;
    logic [FSEL_W-1:0] sel_q;
    logic [CNT_W-1:0]  last_w;
    logic [CNT_W-1:0]  eff_w;

    // Terminal count and effective coarse code for the captured rate.
    always_comb begin
        last_w = {CNT_W{1'b1}} >> sel_q;
        eff_w  = up_q >> sel_q;
    end

    // Counter runs to the terminal count; inputs are captured at the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= {CNT_W{1'b1}};
            up_q   <= '0;
            fine_q <= '0;
            sel_q  <= '0;
        end else if (cnt_q == last_w) begin
            cnt_q  <= '0;
            up_q   <= duty_i[DUTY_W-1:FINE_W];
            fine_q <= duty_i[FINE_W-1:0];
            sel_q  <= fsel_i;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign cnt_o   = cnt_q;
    assign last_o  = last_w;
    assign up_o    = up_q;
    assign fine_o  = fine_q;
    assign sel_o   = sel_q;
    assign start_o = (cnt_q == '0);
    assign match_o = (cnt_q == eff_w);
    assign wrap_o  = (cnt_q == last_w);

endmodule

// File: rtl/hdpwm_tapsel.sv
// Fine stage: selects one delay-line phase marker by the captured fine code.
// Assumes every tap is a clean rising marker within each clock cycle.
module hdpwm_tapsel #(
    parameter int FINE_W = 5,
    localparam int NTAP = 1 << FINE_W
) (
    input  logic [NTAP-1:0]   taps_i,
    input  logic [FINE_W-1:0] sel_i,
    output logic              hit_o
);

    logic [NTAP-1:0] pick_w;

    // One AND term per tap; only the selected tap can pass.
    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        assign pick_w[g] = (sel_i == FINE_W'(g)) & taps_i[g];
    end

    assign hit_o = |pick_w;

endmodule

// File: rtl/hdpwm_edge.sv
// Output stage: holds the pulse from the period start until the coarse match
// cycle, where the selected tap ends it between clock edges.
// Assumes the tap input is monotonic within a clock cycle, so no glitch occurs.
module hdpwm_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic match_i,
    input  logic tap_hit_i,
    output logic pwm_o
);

    logic on_q;
    logic active_w;

    // The pulse is live at a period start or while it has not yet been ended.
    always_comb active_w = start_i | on_q;

    // Remember that the pulse continues into the next cycle of the period.
    always_ff @(posedge clk) begin
        if (!rst_n) on_q <= 1'b0;
        else        on_q <= active_w & ~match_i;
    end

    assign pwm_o = active_w & ~(match_i & tap_hit_i);

endmodule

// File: rtl/hdpwm.sv
// Top: hybrid counter plus delay-tap pulse-width modulator.
// Assumes taps_i comes from an external delay line locked to clk.
module hdpwm #(
    parameter int DUTY_W = 8,
    parameter int CNT_W  = 3,
    parameter int FSEL_W = 2,
    localparam int FINE_W = DUTY_W - CNT_W,
    localparam int NTAP   = 1 << FINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [FSEL_W-1:0] fsel_i,
    input  logic [NTAP-1:0]   taps_i,
    output logic              pwm_o
);

    logic [CNT_W-1:0]  cnt_w;
    logic [CNT_W-1:0]  last_w;
    logic [CNT_W-1:0]  up_w;
    logic [FINE_W-1:0] fine_w;
    logic [FSEL_W-1:0] sel_w;
    logic              start_w;
    logic              match_w;
    logic              wrap_w;
    logic              tap_hit_w;

    // Configuration guard evaluated once at start.
    initial begin
        assert (hdpwm_pkg::cfg_ok(DUTY_W, CNT_W, FSEL_W))
            else $error("hdpwm: inconsistent width parameters");
    end

    hdpwm_coarse #(
        .DUTY_W(DUTY_W), .CNT_W(CNT_W), .FSEL_W(FSEL_W)
    ) u_coarse (
        .clk(clk), .rst_n(rst_n), .duty_i(duty_i), .fsel_i(fsel_i),
        .cnt_o(cnt_w), .last_o(last_w), .up_o(up_w), .fine_o(fine_w),
        .sel_o(sel_w), .start_o(start_w), .match_o(match_w), .wrap_o(wrap_w)
    );

    hdpwm_tapsel #(.FINE_W(FINE_W)) u_tapsel (
        .taps_i(taps_i), .sel_i(fine_w), .hit_o(tap_hit_w)
    );

    hdpwm_edge u_edge (
        .clk(clk), .rst_n(rst_n), .start_i(start_w), .match_i(match_w),
        .tap_hit_i(tap_hit_w), .pwm_o(pwm_o)
    );

endmodule

// File: rtl/hdpwm_chk.sv
// Checker: temporal properties of the modulator, bound into the top module.
module hdpwm_chk #(
    parameter int CNT_W  = 3,
    parameter int FINE_W = 5,
    parameter int FSEL_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwm_o,
    input logic [CNT_W-1:0]  cnt_w,
    input logic [CNT_W-1:0]  last_w,
    input logic [CNT_W-1:0]  up_w,
    input logic [FINE_W-1:0] fine_w,
    input logic [FSEL_W-1:0] sel_w,
    input logic              start_w,
    input logic              match_w,
    input logic              wrap_w
);

    AST_RESET_LOW: assert property (@(posedge clk) !rst_n |=> !pwm_o); // R8
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt_w <= last_w); // R4
    AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n) !start_w |-> $stable({up_w, fine_w, sel_w})); // R5
    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n) (up_w == '0 && fine_w == '0) |-> !pwm_o); // R6
    AST_LOW_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n) (match_w && !wrap_w) |=> !pwm_o); // R3
    AST_HIGH_BEFORE_MATCH: assert property (@(posedge clk) disable iff (!rst_n) (start_w && !match_w) |-> pwm_o); // R2

endmodule

bind hdpwm hdpwm_chk #(.CNT_W(CNT_W), .FINE_W(FINE_W), .FSEL_W(FSEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwm_o(pwm_o), .cnt_w(cnt_w), .last_w(last_w),
    .up_w(up_w), .fine_w(fine_w), .sel_w(sel_w), .start_w(start_w),
    .match_w(match_w), .wrap_w(wrap_w)
);

// File: tb/hdpwm_tb.sv
`timescale 1ns/1ps
// Bench: sweeps every duty code at every rate select and counts high tap
// steps per 8-clock window against arithmetic expectations.
module hdpwm_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  duty = '0;
    logic [1:0]  fsel = '0;
    logic [31:0] taps = '0;
    logic        pwm;

    int n_chk = 0;
    int n_err = 0;
    int hi_cnt = 0;
    int rise_cnt = 0;
    int first_hi = 0;
    int step_idx = 0;
    bit prev_s = 1'b0;
    bit done = 1'b0;

    hdpwm u_dut (
        .clk(clk), .rst_n(rst_n), .duty_i(duty), .fsel_i(fsel),
        .taps_i(taps), .pwm_o(pwm)
    );

    always #4 clk = ~clk;

    // Delay-line model: tap k rises k quarter-ns steps after each edge; the
    // output is sampled in the middle of every step.
    always @(posedge clk) begin
        taps = 32'h1;
        for (int k = 0; k < 32; k++) begin
            #0.125;
            if (pwm) hi_cnt++;
            if (pwm && !prev_s) rise_cnt++;
            if (step_idx == 0) first_hi = int'(pwm);
            step_idx++;
            prev_s = pwm;
            if (k < 31) begin
                #0.125;
                taps[k+1] = 1'b1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clr();
        hi_cnt = 0;
        rise_cnt = 0;
        step_idx = 0;
    endtask

    // One 8-clock window; inputs set now, optional mid-window duty change.
    task automatic run_win(input logic [7:0] d, input logic [1:0] s,
                           input bit mid, input logic [7:0] d_mid, input string tag);
        int per_clk, m, per, hi_exp;
        duty = d;
        fsel = s;
        @(posedge clk);
        #0.05;
        clr();
        if (mid) begin
            repeat (3) @(posedge clk);
            #2;
            duty = d_mid;
            repeat (4) @(posedge clk);
        end else begin
            repeat (7) @(posedge clk);
        end
        #7.95;
        per_clk = 8 >> s;
        m = int'(d[7:5]) >> s;
        per = m * 32 + int'(d[4:0]);
        hi_exp = per * (8 / per_clk);
        chk({tag, " high steps"}, hi_cnt, hi_exp);
        chk({"R3 pulses per window ", tag}, rise_cnt, (per > 0) ? (8 / per_clk) : 0);
        chk({"R2 high at period start ", tag}, first_hi, (per > 0) ? 1 : 0);
    endtask

    // Hold reset for several clocks and confirm the output never goes high.
    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        duty = 8'hA5;
        @(posedge clk);
        #0.05;
        clr();
        repeat (4) @(posedge clk);
        #7.95;
        chk("R8 low during reset", hi_cnt, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        string tag;
        hold_reset();
        // R8: first window after release uses inputs present at the first edge.
        run_win(8'd77, 2'd0, 1'b0, 8'd0, "R8 first period after release");
        // R5: mid-period change ignored for the period, then applied.
        run_win(8'd40, 2'd0, 1'b1, 8'd200, "R5 mid-period change ignored");
        run_win(8'd200, 2'd0, 1'b0, 8'd0, "R5 new value in next period");
        // Full sweep of all codes at all rates.
        for (int s = 0; s < 4; s++) begin
            for (int d = 0; d < 256; d++) begin
                if (d == 0)                tag = "R6 zero duty";
                else if (d == 255 && s == 0) tag = "R7 max code";
                else if (s != 0)           tag = "R4 rate select";
                else                       tag = "R1 duty split";
                run_win(8'(d), 2'(s), 1'b0, 8'd0, tag);
            end
        end
        // R8: reset in mid operation, then restart.
        hold_reset();
        run_win(8'd255, 2'd0, 1'b0, 8'd0, "R8 restart after reset");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule